// File: doc/BRIEF.md
# Latched Bidirectional Backplane Transceiver

This block joins an 8-bit local port (A, tri-state outputs) to a wired-OR backplane port (B, open-drain outputs that can only pull a line low or let it go). A single data latch serves both directions. The direction of loading follows the enables. When the A drivers are on and the B drivers are off, the latch takes its data from B and hands it to A. In every other case it takes its data from A. The B drivers come on only when both active-low B enables are asserted, and they invert by default: a stored 1 pulls the line low.

The design is clocked and suited to an FPGA. Controls and data are sampled on the rising clock edge. While the latch enable is low the latch reloads on every edge, and while it is high the latch holds. All outputs come from registered state, so an input change shows at the ports one clock later. Each port has separate in, out and enable signals, plus a per-bit presence mask for B. A flag reports the feedback configuration: both ports driving while the latch is open. The parameter `INVERT` selects the inverting B path (1) or the non-inverting one (0).

Top module: `bidir_latch_xcvr`

## Requirements
- R1: When `le_n` is 0 at a clock edge the latch loads the selected source on that edge. When `le_n` is 1 the latch keeps its value, and `a_out` stays stable.
- R2: `b_oe` can have bits set only if both bits of `b_en_n` were 0 at the previous edge. Otherwise `b_oe` is all zeros.
- R3: `a_oe` equals the value of `a_dir` sampled at the previous edge.
- R4: With `INVERT`=1 and the B drivers enabled, `b_oe[i]` equals latch bit i (a 1 pulls the line low) and `b_out` is always 0. With `INVERT`=0, `b_oe[i]` is the complement of latch bit i.
- R5: When `a_dir`=1 and the B drivers are not both enabled, an open latch loads the received B data. With `INVERT`=1 this is the complement of the sampled line.
- R6: When `a_dir`=0, an open latch loads `a_in`, whatever the value of `b_en_n`.
- R7: A B bit whose `b_pres` bit is 0 counts as a low line level before decoding.
- R8: `feedback` is 1 one clock after an edge where `a_dir`=1, `b_en_n`=00 and `le_n`=0. In that case the latch loads from `a_in`.
- R9: With the latch closed and both ports enabled, `a_out` and the B pull mask both show the held latch value.
- R10: Synchronous reset clears the latch, `a_oe`, `b_oe` and `feedback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| le_n | input | 1 | Latch enable, active low |
| a_dir | input | 1 | A output enable, active high |
| b_en_n | input | 2 | B output enables, both active low |
| a_in | input | W | Data received on port A |
| a_out | output | W | Latch value presented on port A |
| a_oe | output | 1 | Tri-state enable for port A |
| b_in | input | W | Sampled backplane line levels |
| b_pres | input | W | Per-bit mask, 0 = line not driven |
| b_out | output | W | Open-drain data, always 0 |
| b_oe | output | W | Per-bit pull-down enable for port B |
| feedback | output | 1 | Feedback configuration flag |

## Verification
The hardest case to reach is a load from B right after the B drivers turn off. On that edge the backplane still carries the pull-downs from the previous configuration, because `b_oe` is registered. The bench models the bus as a wired-AND with a pull-up, driven from the design's live outputs. It steps through all sixteen control combinations in many orders, so every such hand-over occurs with varied data and presence masks. Its own model uses its previous expected pull mask to predict the value that lands in the latch.

// File: rtl/bidir_latch_pkg.sv
package bidir_latch_pkg;

  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_sel_e;

endpackage

// File: rtl/bidir_latch_ctrl.sv
module bidir_latch_ctrl
  import bidir_latch_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     le_n,
  input  logic     a_dir,
  input  logic [1:0] b_en_n,
  output src_sel_e src_sel,
  output logic     load,
  output logic     a_en_q,
  output logic     b_en_q,
  output logic     fb_q
);
  logic b_on;

  always_comb begin
    b_on    = (b_en_n == 2'b00);
    load    = ~le_n;
    src_sel = (a_dir && !b_on) ? SRC_B : SRC_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_en_q <= 1'b0;
      b_en_q <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      a_en_q <= a_dir;
      b_en_q <= b_on;
      fb_q   <= a_dir & b_on & ~le_n;
    end
  end

  p_src_a_when_a_off_r6: assert property (@(posedge clk) disable iff (rst)
    !a_dir |-> src_sel == SRC_A);
  p_fb_uses_a_r8: assert property (@(posedge clk) disable iff (rst)
    (a_dir && b_en_n == 2'b00) |-> src_sel == SRC_A);
endmodule

// File: rtl/bidir_latch_bport.sv
module bidir_latch_bport #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b1
) (
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_pres,
  input  logic [W-1:0] q,
  input  logic         b_en_q,
  output logic [W-1:0] rx,
  output logic [W-1:0] pull
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic lvl;
    assign lvl = b_in[i] & b_pres[i];
    if (INVERT) begin : g_inv
      assign rx[i]   = ~lvl;
      assign pull[i] = b_en_q & q[i];
    end else begin : g_buf
      assign rx[i]   = lvl;
      assign pull[i] = b_en_q & ~q[i];
    end
  end
endmodule

// File: rtl/bidir_latch_store.sv
module bidir_latch_store
  import bidir_latch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  src_sel_e     src_sel,
  input  logic [W-1:0] a_src,
  input  logic [W-1:0] b_src,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (load) q <= (src_sel == SRC_B) ? b_src : a_src;
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import bidir_latch_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le_n,
  input  logic         a_dir,
  input  logic [1:0]   b_en_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_pres,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         feedback
);
  src_sel_e     src_sel;
  logic         load, a_en_q, b_en_q, fb_q;
  logic [W-1:0] q, rx, pull;

  bidir_latch_ctrl u_ctrl (
    .clk(clk), .rst(rst), .le_n(le_n), .a_dir(a_dir), .b_en_n(b_en_n),
    .src_sel(src_sel), .load(load), .a_en_q(a_en_q), .b_en_q(b_en_q), .fb_q(fb_q)
  );

  bidir_latch_bport #(.W(W), .INVERT(INVERT)) u_bport (
    .b_in(b_in), .b_pres(b_pres), .q(q), .b_en_q(b_en_q), .rx(rx), .pull(pull)
  );

  bidir_latch_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .load(load), .src_sel(src_sel),
    .a_src(a_in), .b_src(rx), .q(q)
  );

  assign a_out    = q;
  assign a_oe     = a_en_q;
  assign b_out    = '0;
  assign b_oe     = pull;
  assign feedback = fb_q;

  p_b_needs_both_r2: assert property (@(posedge clk) disable iff (rst)
    (b_en_n != 2'b00) |=> b_oe == '0);
  p_a_enable_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_oe == $past(a_dir));
  p_fb_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (a_dir && b_en_n == 2'b00 && !le_n) |=> feedback);
  p_b_out_low_r4: assert property (@(posedge clk) disable iff (rst)
    b_out == '0);
  p_aout_hold_r1: assert property (@(posedge clk) disable iff (rst)
    le_n |=> $stable(a_out));
endmodule

// File: tb/sim_bidir_latch_xcvr.sv
module sim_bidir_latch_xcvr;
  localparam int W = 8;

  typedef struct {
    logic         a_oe;
    logic [W-1:0] a_out;
    logic [W-1:0] b_oe;
    logic         fb;
    logic [W-1:0] line;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic le_n = 1'b1, a_dir = 1'b0;
  logic [1:0] b_en_n = 2'b11;
  logic [W-1:0] a_in = '0, ext = '1, b_pres = '1;
  logic [W-1:0] a_out, b_out, b_oe, b_in;
  logic a_oe, feedback;

  int checks = 0, errors = 0;
  exp_t q_exp[$];
  logic [W-1:0] m_q = '0, m_pull = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #2.5 clk = ~clk;

  // backplane: wired-AND with pull-up, external drivers and the design's pull-downs
  assign b_in = ext & ~(b_oe & ~b_out);

  bidir_latch_xcvr #(.W(W), .INVERT(1'b1)) u0 (
    .clk(clk), .rst(rst), .le_n(le_n), .a_dir(a_dir), .b_en_n(b_en_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_pres(b_pres),
    .b_out(b_out), .b_oe(b_oe), .feedback(feedback)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic drive(input logic le, input logic ad, input logic [1:0] ben,
                       input logic [W-1:0] a, input logic [W-1:0] e, input logic [W-1:0] pr);
    exp_t it;
    logic [W-1:0] line_now, rx;
    logic bon, ldb;
    @(negedge clk);
    le_n = le; a_dir = ad; b_en_n = ben; a_in = a; ext = e; b_pres = pr;
    line_now = e & ~m_pull;              // pulls still from the previous configuration
    rx = ~(line_now & pr);               // R7: absent bit reads low, R5: inverted
    bon = (ben == 2'b00);
    ldb = ad & ~bon;
    if (!le) m_q = ldb ? rx : a;
    m_pull = bon ? m_q : '0;
    it.a_oe = ad; it.a_out = m_q; it.b_oe = m_pull;
    it.fb = ad & bon & ~le; it.line = e & ~m_pull;
    if (le) it.tag = (ad && bon) ? "R9" : "R1";
    else if (ldb) it.tag = (pr != '1) ? "R7" : "R5";
    else if (ad) it.tag = "R8";
    else it.tag = "R6";
    q_exp.push_back(it);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      exp_t it;
      it = q_exp.pop_front();
      chk(it.tag, a_out, it.a_out);
      chk("R3", {7'b0, a_oe}, {7'b0, it.a_oe});
      chk(it.b_oe == '0 ? "R2" : "R4", b_oe, it.b_oe);
      chk("R4 b_out", b_out, '0);
      chk("R8", {7'b0, feedback}, {7'b0, it.fb});
      chk("R4 line", b_in, it.line);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 a_out", a_out, '0);
    chk("R10 a_oe", {7'b0, a_oe}, '0);
    chk("R10 b_oe", b_oe, '0);
    chk("R10 fb", {7'b0, feedback}, '0);
    @(negedge clk); rst = 1'b0;
    // directed: load from A, then close and drive both (R9), then feedback
    drive(1'b0, 1'b0, 2'b11, 8'hA5, 8'hFF, 8'hFF);
    drive(1'b1, 1'b1, 2'b00, 8'h3C, 8'hFF, 8'hFF);
    drive(1'b0, 1'b1, 2'b00, 8'h5A, 8'hFF, 8'hFF);
    // hand-over: B off right after pulling, load from B
    drive(1'b0, 1'b1, 2'b10, 8'h00, 8'hF0, 8'hFF);
    drive(1'b0, 1'b1, 2'b01, 8'h00, 8'hFF, 8'h0F);
    // sweep every control combination with varied data
    for (int r = 0; r < 40; r++) begin
      for (int c = 0; c < 16; c++) begin
        int cc;
        lfsr = step(lfsr);
        cc = (c + r * 7) % 16;
        drive(cc[3], cc[2], cc[1:0], lfsr[7:0], lfsr[15:8] | 8'h11,
              (r % 3 == 0) ? lfsr[11:4] : 8'hFF);
      end
    end
    @(negedge clk);
    le_n = 1'b1;
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule